// File: doc/BRIEF.md
# Snoop Response Combiner and Memory Gate

This block sits beside the memory controller on a shared, atomic snooping bus with a parameterised number of caches. After each address phase, every cache drives three wire-OR style snoop lines: a copy-held flag, a modified-copy flag and a lookup-busy flag. The block models each line as an OR across all caches. Snoop latency is variable. The block waits until no cache is still busy, and only then latches the combined result.

In the cycle after resolution it gives a one-cycle verdict. The verdict tells the memory controller either to answer the request or to stay silent. Memory stays silent when a cache owns a modified copy, because that cache supplies the data. It also stays silent when an exclusive read finds sharers. The same pulse tells the requester whether the line was shared or dirty, and in which state to fill it. If the busy line stays up longer than a programmed limit, a watchdog reports an error with a single-cycle pulse. Only one transaction is handled at a time. Address phases that arrive while a transaction is open are dropped.

Top module: `snoop_resp_combiner`

## Requirements
- R1: The combined copy, modified and busy lines are each the OR of the matching per-cache inputs, so one cache asserting a line is enough.
- R2: The result resolves on the first cycle after the accepted address-phase cycle in which no cache drives busy. `rsp_valid` rises on the next cycle and stays high for exactly one cycle. If busy is held for P cycles after the address cycle, `rsp_valid` is high in cycle P+2, counting the address cycle as cycle 0.
- R3: `rsp_shared` and `rsp_dirty` show the combined copy and modified lines as sampled in the resolution cycle. Values these lines held in earlier busy cycles have no effect.
- R4: If the modified line was set, `mem_suppress` is asserted and `mem_respond` is not, whatever the request kind.
- R5: An exclusive read (`req_excl`=1) that found the copy line set suppresses memory.
- R6: `fill_state` during `rsp_valid` uses this encoding: 2'd3 (modified) for any exclusive read; 2'd1 (shared) for a plain read with the copy or modified line set; 2'd2 (exclusive) for a plain read with neither line set. It reads 2'd0 when no result is being delivered.
- R7: Outside `rsp_valid`, `mem_respond` and `mem_suppress` are both low. During `rsp_valid`, exactly one of them is high. A plain read with the modified line clear gets `mem_respond`.
- R8: `tmo_err` pulses for one cycle when busy has been seen on `tmo_limit`+1 consecutive cycles of an open transaction. The pulse occurs in cycle `tmo_limit`+2 after the address cycle, at most once per transaction. The transaction still completes normally.
- R9: An `addr_valid` that arrives while a transaction is waiting for its snoop result, or while its result is being delivered, is ignored. It produces no extra result.
- R10: After reset, every output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr_valid | input | 1 | Address phase of a read on the bus |
| req_excl | input | 1 | Request is an exclusive (for-ownership) read |
| snp_hit | input | N_CACHES | Per-cache "holds a copy" line |
| snp_dirty | input | N_CACHES | Per-cache "holds a modified copy" line |
| snp_pending | input | N_CACHES | Per-cache "lookup still in progress" line |
| tmo_limit | input | CNT_W | Permitted busy cycles before timeout |
| rsp_valid | output | 1 | One-cycle result strobe |
| rsp_shared | output | 1 | Combined copy status |
| rsp_dirty | output | 1 | Combined modified status |
| fill_state | output | 2 | Fill state for the requester |
| mem_respond | output | 1 | Memory shall supply the data |
| mem_suppress | output | 1 | Memory shall stay silent |
| tmo_err | output | 1 | Snoop timeout pulse |

## Verification
The bound checker enforces several properties on every cycle. The result strobe is one cycle wide, and it rises only after a cycle in which no cache was busy. Memory gets exactly one verdict per strobe and none outside it. A modified copy or an exclusive read with sharers always silences memory, every strobe carries a non-zero fill code, and a timeout pulse never repeats on the next cycle. Three behaviours can only be shown by the bench scenarios, which compare against a scoreboard of expected results and arrival cycles. These are the exact latency for a given busy length, the fact that earlier-cycle snoop values are discarded, and the dropping of address phases that arrive mid-transaction.

// File: rtl/snoop_comb_pkg.sv
package snoop_comb_pkg;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_SNOOP = 2'd1,
    PH_DELIV = 2'd2
  } phase_e;

  typedef enum logic [1:0] {
    FILL_NONE   = 2'd0,
    FILL_SHARED = 2'd1,
    FILL_EXCL   = 2'd2,
    FILL_MOD    = 2'd3
  } fill_e;

  // memory is allowed to answer unless an owner exists or an ownership read found sharers
  function automatic logic mem_may_answer(input logic excl, input logic shared,
                                          input logic dirty);
    return !dirty && !(excl && shared);
  endfunction

  function automatic fill_e pick_fill(input logic excl, input logic shared,
                                      input logic dirty);
    if (excl)                return FILL_MOD;
    else if (shared || dirty) return FILL_SHARED;
    else                      return FILL_EXCL;
  endfunction

endpackage

// File: rtl/snoop_line_merge.sv
module snoop_line_merge #(
  parameter int N_CACHES = 4
) (
  input  logic [N_CACHES-1:0] hit_vec,
  input  logic [N_CACHES-1:0] dirty_vec,
  input  logic [N_CACHES-1:0] pend_vec,
  output logic                any_hit,
  output logic                any_dirty,
  output logic                any_pend
);
  // wire-OR of the open-collector lines
  assign any_hit   = |hit_vec;
  assign any_dirty = |dirty_vec;
  assign any_pend  = |pend_vec;
endmodule

// File: rtl/snoop_watchdog.sv
module snoop_watchdog #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             arm,
  input  logic             pend,
  input  logic [CNT_W-1:0] limit,
  output logic             fire
);
  localparam int WIDE = CNT_W + 1;

  logic [WIDE-1:0] seen_q;
  logic [WIDE-1:0] lim_w;

  assign lim_w = {1'b0, limit};

  // counts busy cycles seen so far; stops one past the limit so it fires once
  always_ff @(posedge clk) begin
    if (!rst_n || !arm)
      seen_q <= '0;
    else if (pend && seen_q <= lim_w)
      seen_q <= seen_q + WIDE'(1);
  end

  assign fire = arm && pend && (seen_q == lim_w);
endmodule

// File: rtl/snoop_resp_combiner.sv
module snoop_resp_combiner
  import snoop_comb_pkg::*;
#(
  parameter int N_CACHES = 4,
  parameter int CNT_W    = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                addr_valid,
  input  logic                req_excl,
  input  logic [N_CACHES-1:0] snp_hit,
  input  logic [N_CACHES-1:0] snp_dirty,
  input  logic [N_CACHES-1:0] snp_pending,
  input  logic [CNT_W-1:0]    tmo_limit,
  output logic                rsp_valid,
  output logic                rsp_shared,
  output logic                rsp_dirty,
  output logic [1:0]          fill_state,
  output logic                mem_respond,
  output logic                mem_suppress,
  output logic                tmo_err
);

  phase_e phase_q;
  logic   excl_q, shared_q, dirty_q, tmo_q;

  logic any_hit, any_dirty, any_pend;
  // named internal events
  logic accept_evt, resolve_evt, tmo_evt, snooping;
  logic gate_ok;

  snoop_line_merge #(.N_CACHES(N_CACHES)) u_merge (
    .hit_vec  (snp_hit),
    .dirty_vec(snp_dirty),
    .pend_vec (snp_pending),
    .any_hit  (any_hit),
    .any_dirty(any_dirty),
    .any_pend (any_pend)
  );

  assign snooping    = (phase_q == PH_SNOOP);
  assign accept_evt  = (phase_q == PH_IDLE) && addr_valid;
  assign resolve_evt = snooping && !any_pend;

  snoop_watchdog #(.CNT_W(CNT_W)) u_wdog (
    .clk  (clk),
    .rst_n(rst_n),
    .arm  (snooping),
    .pend (any_pend),
    .limit(tmo_limit),
    .fire (tmo_evt)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q  <= PH_IDLE;
      excl_q   <= 1'b0;
      shared_q <= 1'b0;
      dirty_q  <= 1'b0;
      tmo_q    <= 1'b0;
    end else begin
      tmo_q <= tmo_evt;
      unique case (phase_q)
        PH_IDLE: if (accept_evt) begin
          phase_q <= PH_SNOOP;
          excl_q  <= req_excl;
        end
        PH_SNOOP: if (resolve_evt) begin
          phase_q  <= PH_DELIV;
          shared_q <= any_hit;
          dirty_q  <= any_dirty;
        end
        PH_DELIV: phase_q <= PH_IDLE;
        default:  phase_q <= PH_IDLE;
      endcase
    end
  end

  assign gate_ok      = mem_may_answer(excl_q, shared_q, dirty_q);
  assign rsp_valid    = (phase_q == PH_DELIV);
  assign rsp_shared   = rsp_valid && shared_q;
  assign rsp_dirty    = rsp_valid && dirty_q;
  assign fill_state   = rsp_valid ? pick_fill(excl_q, shared_q, dirty_q) : FILL_NONE;
  assign mem_respond  = rsp_valid && gate_ok;
  assign mem_suppress = rsp_valid && !gate_ok;
  assign tmo_err      = tmo_q;

endmodule

// File: rtl/snoop_resp_combiner_chk.sv
module snoop_resp_combiner_chk #(
  parameter int N_CACHES = 4,
  parameter int CNT_W    = 8
) (
  input logic                clk,
  input logic                rst_n,
  input logic [N_CACHES-1:0] snp_pending,
  input logic                rsp_valid,
  input logic                rsp_shared,
  input logic                rsp_dirty,
  input logic [1:0]          fill_state,
  input logic                mem_respond,
  input logic                mem_suppress,
  input logic                tmo_err
);

  a_r2_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  a_r2_after_clear: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rsp_valid) |-> ($past(|snp_pending) == 1'b0));

  a_r4_dirty_silences: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_dirty) |-> (mem_suppress && !mem_respond));

  a_r5_excl_sharers: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_shared && fill_state == 2'd3) |-> mem_suppress);

  a_r6_fill_coded: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (fill_state != 2'd0));

  a_r7_one_verdict: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> ($countones({mem_respond, mem_suppress}) == 1));

  a_r7_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_valid |-> (!mem_respond && !mem_suppress));

  a_r8_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    tmo_err |=> !tmo_err);

endmodule

bind snoop_resp_combiner snoop_resp_combiner_chk #(
  .N_CACHES(N_CACHES),
  .CNT_W   (CNT_W)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .snp_pending (snp_pending),
  .rsp_valid   (rsp_valid),
  .rsp_shared  (rsp_shared),
  .rsp_dirty   (rsp_dirty),
  .fill_state  (fill_state),
  .mem_respond (mem_respond),
  .mem_suppress(mem_suppress),
  .tmo_err     (tmo_err)
);

// File: tb/test_snoop_resp_combiner.sv
`timescale 1ns/1ps
module test_snoop_resp_combiner;
  localparam int N  = 4;
  localparam int CW = 8;
  localparam int LIM = 5;

  logic clk = 1'b0, rst_n = 1'b0;
  logic addr_valid = 1'b0, req_excl = 1'b0;
  logic [N-1:0] snp_hit = '0, snp_dirty = '0, snp_pending = '0;
  logic [CW-1:0] tmo_limit = CW'(LIM);
  logic rsp_valid, rsp_shared, rsp_dirty, mem_respond, mem_suppress, tmo_err;
  logic [1:0] fill_state;

  int tests = 0, fails = 0, cyc = 0, n_rsp = 0, n_exp = 0;
  bit done = 0;

  typedef struct {
    int at; logic sh; logic dy; logic [1:0] fill; logic resp;
  } exp_t;
  exp_t rq[$];
  int   tq[$];

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  snoop_resp_combiner #(.N_CACHES(N), .CNT_W(CW)) i_snoop_resp_combiner (
    .clk(clk), .rst_n(rst_n), .addr_valid(addr_valid), .req_excl(req_excl),
    .snp_hit(snp_hit), .snp_dirty(snp_dirty), .snp_pending(snp_pending),
    .tmo_limit(tmo_limit), .rsp_valid(rsp_valid), .rsp_shared(rsp_shared),
    .rsp_dirty(rsp_dirty), .fill_state(fill_state), .mem_respond(mem_respond),
    .mem_suppress(mem_suppress), .tmo_err(tmo_err));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // driver: pushes expectation, then plays the snoop phase
  task automatic run_txn(input logic excl, input logic [N-1:0] hit, input logic [N-1:0] dty,
                         input logic [N-1:0] e_hit, input logic [N-1:0] e_dty,
                         input int p, input logic poke);
    exp_t e;
    int c0;
    logic sh, dy;
    @(negedge clk);
    c0 = cyc;
    addr_valid = 1'b1; req_excl = excl;
    snp_hit = e_hit; snp_dirty = e_dty; snp_pending = '0;
    sh = |hit; dy = |dty;
    e.at = c0 + p + 2; e.sh = sh; e.dy = dy;
    e.fill = excl ? 2'd3 : ((sh || dy) ? 2'd1 : 2'd2);
    e.resp = !dy && !(excl && sh);
    rq.push_back(e); n_exp++;
    if (p > LIM) tq.push_back(c0 + LIM + 2);
    for (int i = 1; i <= p; i++) begin
      @(negedge clk);
      addr_valid = poke; req_excl = ~excl;
      snp_pending = N'(1) << (i % N);
    end
    @(negedge clk);
    addr_valid = poke; snp_pending = '0; snp_hit = hit; snp_dirty = dty;
    @(negedge clk);
    addr_valid = poke;
    @(negedge clk);
    addr_valid = 1'b0; req_excl = 1'b0; snp_hit = '0; snp_dirty = '0;
  endtask

  // monitor / scoreboard
  always @(negedge clk) if (rst_n) begin
    if (rsp_valid) begin
      n_rsp++;
      if (rq.size() == 0) chk(0, "R9 unexpected result", 1, 0);
      else begin
        exp_t e;
        e = rq.pop_front();
        chk(cyc == e.at, "R2 latency", cyc, e.at);
        chk(rsp_shared == e.sh, "R1/R3 shared", rsp_shared, e.sh);
        chk(rsp_dirty == e.dy, "R1/R3 dirty", rsp_dirty, e.dy);
        chk(fill_state == e.fill, "R6 fill", fill_state, e.fill);
        chk(mem_respond == e.resp && mem_suppress == !e.resp,
            e.dy ? "R4 gate" : "R5/R7 gate", {mem_respond, mem_suppress}, {e.resp, !e.resp});
      end
    end else if (mem_respond || mem_suppress) begin
      chk(0, "R7 verdict outside strobe", {mem_respond, mem_suppress}, 0);
    end
    if (tmo_err) begin
      if (tq.size() == 0) chk(0, "R8 unexpected timeout", cyc, -1);
      else begin
        int t;
        t = tq.pop_front();
        chk(cyc == t, "R8 timeout cycle", cyc, t);
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk({rsp_valid, rsp_shared, rsp_dirty, fill_state, mem_respond, mem_suppress, tmo_err} == '0,
        "R10 reset outputs", {rsp_valid, fill_state, mem_respond, mem_suppress, tmo_err}, 0);
    rst_n = 1'b1;
    // R7/R6: clean plain read -> memory answers, exclusive fill
    run_txn(0, 4'b0000, 4'b0000, 4'b0000, 4'b0000, 0, 0);
    // R1: single cache (index 3) holds a copy -> shared fill, memory answers
    run_txn(0, 4'b1000, 4'b0000, 4'b0000, 4'b0000, 2, 0);
    // R4: modified copy in cache 1 -> suppress
    run_txn(0, 4'b0010, 4'b0010, 4'b0000, 4'b0000, 3, 0);
    // R5: exclusive read with sharers -> suppress, modified fill
    run_txn(1, 4'b0101, 4'b0000, 4'b0000, 4'b0000, 1, 0);
    // R6: exclusive read, no sharers -> memory answers, modified fill
    run_txn(1, 4'b0000, 4'b0000, 4'b0000, 4'b0000, 0, 0);
    // R4: exclusive read with an owner
    run_txn(1, 4'b0001, 4'b0100, 4'b0000, 4'b0000, 2, 0);
    // R3: lines set during busy cycles, clear at resolution
    run_txn(0, 4'b0000, 4'b0000, 4'b1111, 4'b1111, 4, 0);
    // R3: lines clear during busy cycles, set at resolution
    run_txn(0, 4'b0100, 4'b0000, 4'b0000, 4'b0000, 3, 0);
    // R9: address phases poked while busy and while delivering
    run_txn(0, 4'b0010, 4'b0000, 4'b0000, 4'b0000, 4, 1);
    run_txn(1, 4'b0000, 4'b0000, 4'b0000, 4'b0000, 0, 1);
    // R8: at the limit (no timeout), just past it, well past it
    run_txn(0, 4'b0000, 4'b0000, 4'b0000, 4'b0000, LIM, 0);
    run_txn(0, 4'b0001, 4'b0000, 4'b0000, 4'b0000, LIM + 1, 0);
    run_txn(1, 4'b0000, 4'b1000, 4'b0000, 4'b0000, LIM + 6, 0);
    repeat (8) @(negedge clk);
    chk(n_rsp == n_exp, "R9 result count", n_rsp, n_exp);
    chk(rq.size() == 0, "R2 missing results", rq.size(), 0);
    chk(tq.size() == 0, "R8 missing timeouts", tq.size(), 0);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule